// File: doc/BRIEF.md
# Load/Store Byte-Lane Formatter

This block sits between a 32-bit big-endian memory bus and a 32-bit register file. On the load side, it takes the raw word returned by memory and selects the addressed byte or halfword. It then optionally reverses the byte order and fills the upper bits with zeros or with copies of the sign bit. The result is ready to be written to a register.

On the store side, it takes register data and places the low byte, the low halfword or the whole word on the lanes that the address selects. The placed data can also be byte-reversed. It produces a matching 4-bit byte-enable pattern.

Every access passes through a single pipeline register. One access can be accepted on every clock, and its formatted result appears one cycle later.

The address bits used here are the two lowest bits of the byte address. Lane numbering follows the big-endian rule. Byte lane k, the byte at address offset k, occupies data bits [31-8k : 24-8k]. Byte-enable bit k belongs to that lane. Size codes are 0 for byte, 1 for halfword, 2 for word and 3 for reserved.

Top module: `ldst_lane_fmt`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid`, `out_be` and `out_misalign` are all zero.
- R2: Each access is accepted in the cycle where `in_valid` is high. Its result appears with `out_valid` high exactly one clock later. Back-to-back accesses on consecutive cycles each produce a result, in order. An idle input cycle produces `out_valid` low.
- R3: For a byte load (size 0) at offset a, the result's low 8 bits are memory bits [31-8a : 24-8a]. With `in_signed` low, bits [31:8] are zero. With `in_reverse` high, the result is unchanged.
- R4: With `in_signed` high, a byte load copies its bit 7 into result bits [31:8]. A halfword load copies its bit 15 into result bits [31:16].
- R5: A halfword load (size 1) takes memory bits [31:16] when address bit 1 is 0, and bits [15:0] when it is 1. With `in_reverse` high, the two bytes are swapped before extension.
- R6: A word load (size 2) returns the memory word unchanged. With `in_reverse` high, the lanes are mirrored: bits [7:0] move to [31:24], [15:8] to [23:16], [23:16] to [15:8] and [31:24] to [7:0].
- R7: A byte store places `in_data[7:0]` on lane a. All other data bits are zero, and `out_be` has only bit a set.
- R8: A halfword store places `in_data[15:0]` on bits [31:16] when address bit 1 is 0, with `out_be` = 4'b0011. When address bit 1 is 1, it places the halfword on bits [15:0], with `out_be` = 4'b1100. The other bits are zero. With `in_reverse` high, the two bytes are swapped first.
- R9: A word store drives `out_be` = 4'b1111. The data is `in_data`, or `in_data` with its lanes mirrored as in R6 when `in_reverse` is high.
- R10: `out_misalign` is high for these accesses, and for no others:
  - a halfword access with address bit 0 set;
  - a word access with a non-zero offset;
  - any access with size 3.

  A misaligned store drives `out_be` = 0. For a misaligned load, the data output is undefined.
- R11: A load always drives `out_be` = 0. `out_is_store` repeats the direction of the access it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An access is presented this cycle |
| in_is_store | input | 1 | 1 = store, 0 = load |
| in_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| in_addr_lo | input | 2 | Byte offset within the word |
| in_signed | input | 1 | Sign-fill a byte or halfword load |
| in_reverse | input | 1 | Reverse the byte order of the access |
| in_data | input | 32 | Memory word (load) or register data (store) |
| out_valid | output | 1 | Result of the access from the previous cycle |
| out_is_store | output | 1 | Direction of that access |
| out_data | output | 32 | Extended load result, or lane-placed store data |
| out_be | output | 4 | Store byte enables, bit k for lane k |
| out_misalign | output | 1 | The access was misaligned |

## Verification
A wrong lane select or swap stays inside the pipeline register for exactly one cycle. It then shows on `out_data` in the cycle after the access as a byte in the wrong position or a wrong fill pattern. A corrupted valid or byte-enable state shows at once on `out_valid` or `out_be` in that same following cycle. It never lingers, because every access fully reloads the stage. For that reason, every size, offset, sign and reverse combination is sent back to back, in both directions, and each result is compared in the cycle it emerges.

// File: rtl/lsf_pkg.sv
// Package: shared widths and the access-size encoding for the lane formatter.
// Assumes a 32-bit data path made of four 8-bit lanes.
package lsf_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int OFS_W  = $clog2(LANES);
    localparam int HALF_W = 2 * LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              is_store;
        logic              misalign;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
    } fmt_res_t;
endpackage

// File: rtl/lsf_align_chk.sv
// Module: alignment decoder. It flags accesses whose offset does not
// suit their size, and reserved size codes.
// Assumes a word is the full data width.
module lsf_align_chk
    import lsf_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [OFS_W-1:0] ofs,
    output logic             misalign
);
    // Decide misalignment from size and offset.
    always_comb begin
        unique case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = ofs[0];
            SZ_WORD: misalign = |ofs;
            default: misalign = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsf_load_fmt.sv
// Module: load formatter. It selects the addressed byte or halfword from a
// big-endian memory word, optionally reverses its bytes, and extends it to
// the full width.
// Assumes lane k lies at bits [DATA_W-1-8k -: 8].
// Output is zero on a misaligned access.
module lsf_load_fmt
    import lsf_pkg::*;
(
    input  logic [DATA_W-1:0] mem,
    input  logic [1:0]        size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              sgn,
    input  logic              rev,
    input  logic              misalign,
    output logic [DATA_W-1:0] res
);
    logic [LANE_W-1:0] lane [LANES];
    logic [LANE_W-1:0] pick_b;
    logic [HALF_W-1:0] pick_h;
    logic [DATA_W-1:0] mirror;
    logic [OFS_W-1:0]  h_hi;
    logic [OFS_W-1:0]  h_lo;

    // Split the memory word into big-endian lanes and build the mirrored word.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane[k] = mem[DATA_W-1-LANE_W*k -: LANE_W];
        assign mirror[LANE_W*k +: LANE_W] = lane[k];
    end

    assign h_hi = {ofs[OFS_W-1:1], 1'b0};
    assign h_lo = {ofs[OFS_W-1:1], 1'b1};

    // Pick the addressed byte and the (optionally swapped) halfword.
    always_comb begin
        pick_b = lane[ofs];
        pick_h = rev ? {lane[h_lo], lane[h_hi]} : {lane[h_hi], lane[h_lo]};
    end

    // Extend the selected item to the full width.
    always_comb begin
        if (misalign) begin
            res = '0;
        end else begin
            unique case (size)
                SZ_BYTE: res = {{(DATA_W-LANE_W){sgn & pick_b[LANE_W-1]}}, pick_b};
                SZ_HALF: res = {{(DATA_W-HALF_W){sgn & pick_h[HALF_W-1]}}, pick_h};
                default: res = rev ? mirror : mem;
            endcase
        end
    end
endmodule

// File: rtl/lsf_store_fmt.sv
// Module: store formatter. It places register data on the byte lanes that
// the offset selects, with optional byte reversal, and builds the byte
// enables.
// Assumes the big-endian lane order.
// Misaligned stores produce no enables and zero data.
module lsf_store_fmt
    import lsf_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  logic [1:0]        size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              rev,
    input  logic              misalign,
    output logic [DATA_W-1:0] res,
    output logic [LANES-1:0]  be
);
    logic [LANE_W-1:0] hbyte [2];
    logic [LANE_W-1:0] wbyte [LANES];

    // Order the halfword bytes and the word bytes per the reverse flag.
    always_comb begin
        hbyte[0] = rev ? src[LANE_W-1:0]      : src[HALF_W-1:LANE_W];
        hbyte[1] = rev ? src[HALF_W-1:LANE_W] : src[LANE_W-1:0];
    end

    for (genvar k = 0; k < LANES; k++) begin : g_word
        assign wbyte[k] = rev ? src[LANE_W*k +: LANE_W]
                              : src[DATA_W-1-LANE_W*k -: LANE_W];
    end

    // Drive each lane and its enable from size and offset.
    always_comb begin
        res = '0;
        be  = '0;
        if (!misalign) begin
            for (int k = 0; k < LANES; k++) begin
                unique case (size)
                    SZ_BYTE: if (ofs == OFS_W'(k)) begin
                        be[k] = 1'b1;
                        res[DATA_W-1-LANE_W*k -: LANE_W] = src[LANE_W-1:0];
                    end
                    SZ_HALF: if (ofs[OFS_W-1:1] == (OFS_W-1)'(k/2)) begin
                        be[k] = 1'b1;
                        res[DATA_W-1-LANE_W*k -: LANE_W] = hbyte[k%2];
                    end
                    default: begin
                        be[k] = 1'b1;
                        res[DATA_W-1-LANE_W*k -: LANE_W] = wbyte[k];
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/lsf_stage.sv
// Module: one pipeline register for the formatted result. The valid bit
// follows the input valid bit. The payload loads only on valid input and
// clears on reset.
// Assumes synchronous, active-low reset.
module lsf_stage #(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d_valid,
    input  logic [PAY_W-1:0] d_pay,
    output logic             q_valid,
    output logic [PAY_W-1:0] q_pay
);
    // Register valid and payload on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_pay   <= '0;
        end else begin
            q_valid <= d_valid;
            if (d_valid) q_pay <= d_pay;
        end
    end
endmodule

// File: rtl/ldst_lane_fmt.sv
// Module: top of the load/store byte-lane formatter. It formats a load or
// store combinationally, then registers the result. One access per clock,
// with a latency of one cycle.
// Assumes a big-endian 32-bit bus and 2-bit byte offsets.
module ldst_lane_fmt
    import lsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_is_store,
    input  logic [1:0]        in_size,
    input  logic [OFS_W-1:0]  in_addr_lo,
    input  logic              in_signed,
    input  logic              in_reverse,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_is_store,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_be,
    output logic              out_misalign
);
    localparam int PAY_W = $bits(fmt_res_t);

    logic              mis;
    logic [DATA_W-1:0] ld_res;
    logic [DATA_W-1:0] st_res;
    logic [LANES-1:0]  st_be;
    fmt_res_t          nxt;
    fmt_res_t          cur;

    lsf_align_chk u_align (
        .size     (in_size),
        .ofs      (in_addr_lo),
        .misalign (mis)
    );

    lsf_load_fmt u_load (
        .mem      (in_data),
        .size     (in_size),
        .ofs      (in_addr_lo),
        .sgn      (in_signed),
        .rev      (in_reverse),
        .misalign (mis),
        .res      (ld_res)
    );

    lsf_store_fmt u_store (
        .src      (in_data),
        .size     (in_size),
        .ofs      (in_addr_lo),
        .rev      (in_reverse),
        .misalign (mis),
        .res      (st_res),
        .be       (st_be)
    );

    // Choose the result of the active direction.
    always_comb begin
        nxt.is_store = in_is_store;
        nxt.misalign = mis;
        nxt.be       = in_is_store ? st_be : '0;
        nxt.data     = in_is_store ? st_res : ld_res;
    end

    lsf_stage #(.PAY_W(PAY_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_pay   (nxt),
        .q_valid (out_valid),
        .q_pay   (cur)
    );

    assign out_is_store = cur.is_store;
    assign out_misalign = cur.misalign;
    assign out_be       = cur.be;
    assign out_data     = cur.data;
endmodule

// File: rtl/lsf_chk.sv
// Module: property checker for the formatter. It is bound to the top
// module and watches its ports only.
module lsf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic       out_is_store,
    input logic [3:0] out_be,
    input logic       out_misalign
);
    logic seen;

    // Mark that at least one clock has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R2: the output valid bit is the input valid bit one cycle late.
    a_r2_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> out_valid == $past(in_valid));

    // R1: the first cycle out of reset shows no result.
    a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (!out_valid && out_be == 4'b0 && !out_misalign));

    // R11: a load never enables store lanes.
    a_r11_load_no_be: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_store) |-> out_be == 4'b0);

    // R10: a misaligned store enables no lanes.
    a_r10_mis_no_be: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_misalign) |-> out_be == 4'b0);

    // R8: an aligned store enables one lane, one halfword or all lanes.
    a_r8_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_store && !out_misalign) |->
        (out_be == 4'b0001 || out_be == 4'b0010 || out_be == 4'b0100 ||
         out_be == 4'b1000 || out_be == 4'b0011 || out_be == 4'b1100 ||
         out_be == 4'b1111));
endmodule

bind ldst_lane_fmt lsf_chk u_lsf_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_is_store (out_is_store),
    .out_be       (out_be),
    .out_misalign (out_misalign)
);

// File: tb/test_ldst_lane_fmt.sv
module test_ldst_lane_fmt;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic        is_store;
        logic        mis;
        logic [3:0]  be;
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_is_store = 1'b0;
    logic [1:0]  in_size = 2'd0;
    logic [1:0]  in_addr_lo = 2'd0;
    logic        in_signed = 1'b0;
    logic        in_reverse = 1'b0;
    logic [31:0] in_data = 32'h0;
    logic        out_valid;
    logic        out_is_store;
    logic [31:0] out_data;
    logic [3:0]  out_be;
    logic        out_misalign;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ldst_lane_fmt i_ldst_lane_fmt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_store(in_is_store),
        .in_size(in_size), .in_addr_lo(in_addr_lo), .in_signed(in_signed),
        .in_reverse(in_reverse), .in_data(in_data), .out_valid(out_valid),
        .out_is_store(out_is_store), .out_data(out_data), .out_be(out_be),
        .out_misalign(out_misalign)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lane_of(input logic [31:0] w, input int k);
        return w[31-8*k -: 8];
    endfunction

    // Expected result built from the requirement text.
    function automatic exp_t model(input bit st, input logic [1:0] sz, input logic [1:0] a,
                                   input bit sg, input bit rv, input logic [31:0] d);
        exp_t e;
        logic [15:0] h;
        logic [31:0] mir;
        int hb;
        mir = {d[7:0], d[15:8], d[23:16], d[31:24]};
        e.is_store = st;
        e.mis = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a != 2'd0);
        e.be = 4'b0;
        e.data = 32'h0;
        hb = a[1] ? 2 : 0;
        if (!st) begin
            e.tag = (sz == 2'd0) ? (sg ? "R4 byte" : "R3") : (sz == 2'd1) ? (sg ? "R4 half" : "R5") : "R6";
            case (sz)
                2'd0: e.data = {{24{sg & d[31-8*a]}}, lane_of(d, int'(a))};
                2'd1: begin
                    h = rv ? {lane_of(d, hb+1), lane_of(d, hb)} : {lane_of(d, hb), lane_of(d, hb+1)};
                    e.data = {{16{sg & h[15]}}, h};
                end
                default: e.data = rv ? mir : d;
            endcase
        end else begin
            e.tag = (sz == 2'd0) ? "R7" : (sz == 2'd1) ? "R8" : "R9";
            if (!e.mis) begin
                case (sz)
                    2'd0: begin
                        e.be[a] = 1'b1;
                        e.data[31-8*a -: 8] = d[7:0];
                    end
                    2'd1: begin
                        h = rv ? {d[7:0], d[15:8]} : d[15:0];
                        e.be = a[1] ? 4'b1100 : 4'b0011;
                        e.data[31-16*a[1] -: 16] = h;
                    end
                    default: begin
                        e.be = 4'b1111;
                        e.data = rv ? mir : d;
                    end
                endcase
            end
        end
        if (e.mis) e.tag = "R10";
        return e;
    endfunction

    // Driver: present one access and push its expected result.
    task automatic drive(input bit st, input logic [1:0] sz, input logic [1:0] a,
                         input bit sg, input bit rv, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_is_store = st; in_size = sz; in_addr_lo = a;
        in_signed = sg; in_reverse = rv; in_data = d;
        q.push_back(model(st, sz, a, sg, rv, d));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_data = 32'hDEAD_BEEF;
    endtask

    // Monitor: compare each result as it leaves the stage.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R2 unexpected result", 64'(out_valid), 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(out_is_store == e.is_store, {"R11 dir ", e.tag}, 64'(out_is_store), 64'(e.is_store));
                check(out_misalign == e.mis, {"R10 flag ", e.tag}, 64'(out_misalign), 64'(e.mis));
                check(out_be == e.be, {"be ", e.tag}, 64'(out_be), 64'(e.be));
                if (!(e.mis && !e.is_store))
                    check(out_data == e.data, {"data ", e.tag}, 64'(out_data), 64'(e.data));
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_be == 4'b0 && out_misalign == 1'b0, "R1 in reset",
              {out_valid, out_be, out_misalign}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_be == 4'b0 && out_misalign == 1'b0, "R1 after reset",
              {out_valid, out_be, out_misalign}, 64'd0);
        // Every combination, back to back, over three data words (R2..R11).
        foreach (q[i]) begin end
        for (int w = 0; w < 3; w++) begin
            for (int st = 0; st < 2; st++)
                for (int sz = 0; sz < 4; sz++)
                    for (int a = 0; a < 4; a++)
                        for (int sg = 0; sg < 2; sg++)
                            for (int rv = 0; rv < 2; rv++)
                                drive(st[0], sz[1:0], a[1:0], sg[0], rv[0],
                                      (w == 0) ? 32'h8A7F_F130 : (w == 1) ? 32'h017E_80FF : 32'hC3A5_5A3C);
        end
        // R2: idle gaps produce no result.
        idle();
        @(negedge clk);
        check(out_valid == 1'b0, "R2 idle gives no result", 64'(out_valid), 64'd0);
        drive(1'b0, 2'd0, 2'd3, 1'b1, 1'b0, 32'h0000_0080);
        idle();
        drive(1'b1, 2'd1, 2'd2, 1'b0, 1'b1, 32'h0000_1234);
        idle();
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R2 all results seen", 64'(q.size()), 64'd0);
        summary();
    end
endmodule